// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

The block is a watchdog built around a down-counter that software programs through a small single-cycle register port. Software writes a reload value and arms the counter. The counter then decrements once per clock. When it reaches zero for the first time, the block raises an interrupt and reloads. If software has not serviced the interrupt by the next zero crossing, the block raises a system reset request. That request stays high until the block itself is reset.

Software services the watchdog by writing the interrupt-clear register. This write drops the pending interrupt and restarts the countdown from the reload value. All registers except the lock register are write-protected while the block is locked, and only a fixed 32-bit key written to the lock register opens them. A forced restart is done by programming a reload value of zero and then arming both enables, which produces a reset request within two cycles.

The register port is a plain single-cycle access: address, write enable and write data, with combinational read data. It has no handshake and no back-pressure, because every access completes in the cycle it is presented.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the reload register reads 0xFFFFFFFF, the count reads 0xFFFFFFFF, control reads 0, the lock reads 0 (unlocked), and both `irq_o` and `rst_req_o` are low.
- R2: Read map by byte offset: 0x000 reload value (read/write), 0x004 live count (read-only), 0x008 control bits [1:0], 0x00C interrupt clear (write-only, reads 0), 0x010 raw interrupt in bit 0, 0x014 masked interrupt in bit 0, 0xC00 lock. Unmapped offsets read 0.
- R3: While control bit 0 is set, the count drops by one each cycle. On the cycle it is zero, it reloads from the reload register, so one period is load+1 cycles.
- R4: A zero crossing with the raw interrupt clear sets the raw interrupt. `irq_o` and the masked status equal the raw interrupt ANDed with control bit 0.
- R5: A zero crossing with the raw interrupt already set and control bit 1 set raises `rst_req_o`, 2×(load+1) cycles after the last service. The output then stays high until `rst_n` is asserted.
- R6: A write to the interrupt-clear offset clears the raw interrupt and reloads the count from the reload register. If this write falls in the same cycle as a zero crossing, the write wins and the crossing has no effect.
- R7: An accepted write to the reload register also loads the new value into the count in the same cycle.
- R8: With control bit 0 clear, the count holds its value and `irq_o` is low, while the raw interrupt keeps its state.
- R9: Writing 0x1ACCE551 to the lock offset unlocks the block and any other value locks it. While locked, writes to every other offset are ignored. The lock reads 1 when locked and 0 when unlocked.
- R10: With a reload value of 0, writing control to 3 raises the raw interrupt one cycle later and `rst_req_o` two cycles later.
- R11: With control bit 1 clear, no number of expiries raises `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | First-stage timeout interrupt (masked) |
| rst_req_o | output | 1 | Second-stage reset request, sticky |

## Verification
The two functions that can collide are the service write and the counter's own zero crossing, since both reload the count and both change the raw interrupt. The bench arms the timer, counts clock edges from a known service, and issues the next clear so that its capturing edge is exactly the first or the second zero crossing. It then judges that the interrupt stays low, that no reset request appears, and that the next reset request arrives a full 2×(load+1) edges after that colliding write. The sweep over small reload values checks the count, interrupt and reset on every edge against the closed-form timeline.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned MAP_AW = 12;

  localparam logic [MAP_AW-1:0] OFS_RELOAD = 12'h000;
  localparam logic [MAP_AW-1:0] OFS_COUNT  = 12'h004;
  localparam logic [MAP_AW-1:0] OFS_CTRL   = 12'h008;
  localparam logic [MAP_AW-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [MAP_AW-1:0] OFS_RAW    = 12'h010;
  localparam logic [MAP_AW-1:0] OFS_MASKED = 12'h014;
  localparam logic [MAP_AW-1:0] OFS_GUARD  = 12'hC00;

  localparam logic [31:0] GUARD_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic arm_rst;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] reload_q,
  output ctrl_t         ctrl_q,
  output logic          locked_q,
  output logic          reload_wr,
  output logic          clear_wr
);
  localparam logic [DW-1:0] RELOAD_RST = {DW{1'b1}};

  logic hit_reload, hit_ctrl, hit_clear, hit_guard;
  logic open_wr;

  always_comb begin
    hit_reload = (addr == AW'(OFS_RELOAD));
    hit_ctrl   = (addr == AW'(OFS_CTRL));
    hit_clear  = (addr == AW'(OFS_CLEAR));
    hit_guard  = (addr == AW'(OFS_GUARD));
    open_wr    = we && !locked_q;
    reload_wr  = open_wr && hit_reload;
    clear_wr   = open_wr && hit_clear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= wdata;
      if (open_wr && hit_ctrl) ctrl_q <= ctrl_t'(wdata[1:0]);
      if (we && hit_guard) locked_q <= (wdata != DW'(GUARD_KEY));
    end
  end

  // R9
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && we && !hit_guard) |=> ($stable(reload_q) && $stable(ctrl_q)));

  // R9
  key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_guard && wdata == DW'(GUARD_KEY)) |=> !locked_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] reload_q,
  input  logic          reload_wr,
  input  logic          clear_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count_q,
  output logic          raw_q,
  output logic          rst_req_q
);
  localparam logic [DW-1:0] CNT_RST = {DW{1'b1}};

  logic          restart;
  logic [DW-1:0] restart_val;
  logic          at_zero;
  logic          expire;

  always_comb begin
    restart     = reload_wr || clear_wr;
    restart_val = reload_wr ? wdata : reload_q;
    at_zero     = (count_q == '0);
    expire      = ctrl.run && at_zero && !restart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= CNT_RST;
    end else if (restart) begin
      count_q <= restart_val;
    end else if (ctrl.run) begin
      count_q <= at_zero ? reload_q : count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (clear_wr) begin
      raw_q <= 1'b0;
    end else if (expire) begin
      raw_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
    end else if (expire && raw_q && ctrl.arm_rst) begin
      rst_req_q <= 1'b1;
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !restart && !at_zero) |=> (count_q == $past(count_q) - 1'b1));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !restart) |=> $stable(count_q));

  // R5
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);

  // R5
  rst_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_q) |-> ($past(raw_q) && $past(ctrl.arm_rst)));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |=> (!raw_q && count_q == $past(reload_q)));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] reload_q,
  input  logic [DW-1:0] count_q,
  input  ctrl_t         ctrl,
  input  logic          raw_q,
  input  logic          locked_q,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_RELOAD))      rdata = reload_q;
    else if (addr == AW'(OFS_COUNT))  rdata = count_q;
    else if (addr == AW'(OFS_CTRL))   rdata = DW'(ctrl);
    else if (addr == AW'(OFS_RAW))    rdata = DW'(raw_q);
    else if (addr == AW'(OFS_MASKED)) rdata = DW'(raw_q && ctrl.run);
    else if (addr == AW'(OFS_GUARD))  rdata = DW'(locked_q);
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic [DW-1:0] reload_q;
  logic [DW-1:0] count_q;
  ctrl_t         ctrl_q;
  logic          locked_q;
  logic          reload_wr;
  logic          clear_wr;
  logic          raw_q;

  wdog_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .reload_q(reload_q), .ctrl_q(ctrl_q), .locked_q(locked_q),
    .reload_wr(reload_wr), .clear_wr(clear_wr)
  );

  wdog_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .reload_q(reload_q),
    .reload_wr(reload_wr), .clear_wr(clear_wr), .wdata(reg_wdata),
    .count_q(count_q), .raw_q(raw_q), .rst_req_q(rst_req_o)
  );

  wdog_rdmux #(.DW(DW), .AW(AW)) u_rd (
    .addr(reg_addr), .reload_q(reload_q), .count_q(count_q), .ctrl(ctrl_q),
    .raw_q(raw_q), .locked_q(locked_q), .rdata(reg_rdata)
  );

  assign irq_o = raw_q && ctrl_q.run;

  // R4
  raw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> ($past(count_q) == '0 && $past(ctrl_q.run)));

  // R11
  no_arm_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.arm_rst && !rst_req_o) |=> !rst_req_o);
endmodule

// File: tb/sim_wdog_twostage.sv
module sim_wdog_twostage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = 12'h000;
  logic        we = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq, rstq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                          A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  wdog_twostage u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_o(irq), .rst_req_o(rstq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive in the current low phase; captured at the next posedge
  task automatic wr_now(input logic [11:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    // R1 reset state
    rd(A_LOAD, v); chk("R1 load", v, 32'hFFFFFFFF);
    rd(A_CNT, v);  chk("R1 count", v, 32'hFFFFFFFF);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_LOCK, v); chk("R1 lock", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst", {31'b0, rstq}, 0);
    // R2 write-only and unmapped offsets read zero
    rd(A_CLR, v);  chk("R2 clear reads 0", v, 0);
    rd(12'h100, v); chk("R2 unmapped", v, 0);

    // R3 R4 R5 sweep over small reload values
    for (int L = 0; L <= 10; L++) begin
      do_reset();
      wr(A_LOAD, L);
      wr(A_CTRL, 3);
      wr(A_CLR, 1);
      for (int k = 0; k <= 2 * (L + 1) + 2; k++) begin
        rd(A_CNT, v);
        chk("R3 count", v, L - (k % (L + 1)));
        chk("R4 irq", {31'b0, irq}, (k >= L + 1) ? 1 : 0);
        chk("R5 rst", {31'b0, rstq}, (k >= 2 * (L + 1)) ? 1 : 0);
        @(negedge clk);
      end
      rd(A_RAW, v); chk("R4 raw", v, 1);
      rd(A_MSK, v); chk("R4 masked", v, 1);
    end

    // R6 service collides with the first and then the second zero crossing
    do_reset();
    wr(A_LOAD, 3); wr(A_CTRL, 3); wr(A_CLR, 1);
    repeat (3) @(negedge clk);
    wr_now(A_CLR, 1);                 // captured on edge 4 = first crossing
    rd(A_RAW, v); chk("R6 first collide raw", v, 0);
    rd(A_CNT, v); chk("R6 first collide count", v, 3);
    repeat (3) @(negedge clk);        // edge 4 after service: interrupt
    rd(A_RAW, v); chk("R6 pre-second raw", v, 0);
    @(negedge clk);
    rd(A_RAW, v); chk("R6 interrupt at period", v, 1);
    repeat (3) @(negedge clk);        // position 7 after service
    wr_now(A_CLR, 1);                 // captured on edge 8 = second crossing
    chk("R6 second collide rst", {31'b0, rstq}, 0);
    rd(A_RAW, v); chk("R6 second collide raw", v, 0);
    repeat (7) @(negedge clk);
    chk("R6 no rst before 2 periods", {31'b0, rstq}, 0);
    @(negedge clk);
    chk("R6 rst at 2 periods", {31'b0, rstq}, 1);

    // R5 reset request is sticky
    wr(A_CLR, 1); wr(A_CTRL, 0);
    repeat (5) @(negedge clk);
    chk("R5 sticky", {31'b0, rstq}, 1);
    do_reset();
    chk("R5 cleared by rst_n", {31'b0, rstq}, 0);

    // R7 load write reloads immediately
    wr(A_LOAD, 100); wr(A_CTRL, 1);
    repeat (10) @(negedge clk);
    wr(A_LOAD, 50);
    rd(A_CNT, v); chk("R7 reload", v, 50);
    @(negedge clk);
    rd(A_CNT, v); chk("R7 next", v, 49);

    // R8 freeze masks irq, raw kept
    do_reset();
    wr(A_LOAD, 2); wr(A_CTRL, 1); wr(A_CLR, 1);
    repeat (3) @(negedge clk);
    chk("R8 irq up", {31'b0, irq}, 1);
    wr(A_CTRL, 0);
    rd(A_CNT, v);
    begin
      logic [31:0] held;
      held = v;
      repeat (5) @(negedge clk);
      rd(A_CNT, v); chk("R8 count held", v, held);
    end
    chk("R8 irq masked", {31'b0, irq}, 0);
    rd(A_MSK, v); chk("R8 masked", v, 0);
    rd(A_RAW, v); chk("R8 raw kept", v, 1);

    // R9 lock
    wr(A_LOCK, 1);
    rd(A_LOCK, v); chk("R9 locked", v, 1);
    wr(A_LOAD, 5);
    rd(A_LOAD, v); chk("R9 load ignored", v, 2);
    wr(A_CTRL, 3);
    rd(A_CTRL, v); chk("R9 ctrl ignored", v, 0);
    wr(A_CLR, 1);
    rd(A_RAW, v); chk("R9 clear ignored", v, 1);
    wr(A_LOCK, KEY);
    rd(A_LOCK, v); chk("R9 unlocked", v, 0);
    wr(A_LOAD, 7);
    rd(A_LOAD, v); chk("R9 write after unlock", v, 7);
    wr(A_LOCK, KEY ^ 32'h1);
    rd(A_LOCK, v); chk("R9 near key locks", v, 1);
    wr(A_LOCK, KEY);

    // R10 forced restart
    do_reset();
    wr(A_LOAD, 0);
    wr(A_CTRL, 3);
    rd(A_RAW, v); chk("R10 raw k0", v, 0);
    chk("R10 rst k0", {31'b0, rstq}, 0);
    @(negedge clk);
    rd(A_RAW, v); chk("R10 raw k1", v, 1);
    chk("R10 rst k1", {31'b0, rstq}, 0);
    @(negedge clk);
    chk("R10 rst k2", {31'b0, rstq}, 1);

    // R11 no reset without bit 1
    do_reset();
    wr(A_LOAD, 2); wr(A_CTRL, 1); wr(A_CLR, 1);
    repeat (20) @(negedge clk);
    chk("R11 no rst", {31'b0, rstq}, 0);
    rd(A_RAW, v); chk("R11 raw set", v, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule